// File: doc/BRIEF.md
# Maskable Interrupt Line Controller

This block drives an active-low, push-pull interrupt line towards a host processor. Detection logic elsewhere on the chip delivers one-cycle event pulses; the block latches each pulse into its own status bit and produces a single high-to-low edge on the line to tell the host that something is waiting. The host owns a mask bit, written through a strobe. It acknowledges an interrupt by reading the status, and that read clears the latched bits and releases the line.

The line is low and the mask is set after reset. It stays low until the host first clears the mask, which parks the line high and ready for the next edge. A falling edge is never produced at once. Pending status first waits a switch settling time of `SW_WAIT_CYC` clock cycles, and only then is the line pulled low. When the host's I/O supply indication drops, the block returns to its reset state for `RST_CYC` cycles. It keeps latching events while the supply stays absent, and it reports them once the supply is back and the host has cleared the mask again.

Top module: `irq_line_ctrl`

## Requirements
- R1: While `rst_n` is sampled low, and for the `RST_CYC` cycles after it is sampled high again, `irq_n` is 0 and `evt_status` is all zero. Event pulses and mask writes that arrive in this reset phase are discarded, and the mask is left set (1 means masked).
- R2: After the reset phase, and while the mask remains set, `irq_n` stays 0. Events are latched meanwhile.
- R3: A `mask_wr` strobe loads `mask_wdata` into the mask bit only when `vddio_ok` is 1 and the block is outside the reset phase. In all other cases the write has no effect.
- R4: Clearing the mask from the post-reset state with no status pending raises `irq_n` at the second clock edge after the write is sampled. The line then stays high.
- R5: A pulse on `evt_pulse[i]` sets `evt_status[i]` at the edge that samples it. The bit holds until a status read.
- R6: While unmasked, a newly pending status leaves `irq_n` high for `SW_WAIT_CYC` more edges after the capture edge. `irq_n` goes low at edge `SW_WAIT_CYC`+1 after the capture edge.
- R7: Events latched while masked cause no edge. When the mask is cleared at edge m, `irq_n` rises after edge m+1 and falls after edge m+1+`SW_WAIT_CYC`.
- R8: Setting the mask while running drives `irq_n` high by the second edge after the write, even if the line was asserted. It then stays high, whatever events arrive, until the mask is cleared. From that point the R7 timing applies.
- R9: A `stat_rd` strobe clears every status bit except those whose event pulse is sampled in the same cycle. If the line was asserted, it goes high at the edge that samples the read. Any surviving bits start a fresh wait of `SW_WAIT_CYC` cycles and then a new falling edge.
- R10: Several events that arrive before a read produce a single falling edge on `irq_n`.
- R11: A high-to-low transition of `vddio_ok` has the same effect as R1, reset phase included. Events that arrive after the phase while `vddio_ok` is still 0 are latched. They are reported with the R7 timing once `vddio_ok` is 1 and the mask is cleared.
- R12: `irq_n` falls from high to low only while at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | N_EVT | One-cycle event pulses from detection logic |
| mask_wr | input | 1 | Host strobe that writes the mask bit |
| mask_wdata | input | 1 | Mask value to write (1 = masked) |
| stat_rd | input | 1 | Host status-read acknowledge strobe |
| vddio_ok | input | 1 | Host I/O supply present level |
| irq_n | output | 1 | Active-low interrupt line |
| evt_status | output | N_EVT | Latched event status bits |

## Verification
The bench targets the cycle in which a deferred event finally pulls the line low after unmasking. A design that skipped the settling wait, or asserted the interrupt while still masked, would show the edge several cycles early or show it at all. A read that coincides with a new event is another target: a design that lost that event, or kept the line low through the read, would leave the host either unaware of the event or never given a fresh edge. Mask writes attempted while the supply is absent must not stick, and events during the reset phase must vanish; otherwise the line would rise too soon or report phantom status. Random event and read traffic checks that each read window has at most one falling edge and that no edge appears without pending status.

// File: rtl/irq_line_pkg.sv
// Package: shared state encoding for the interrupt line controller.
// Assumes: consumed by irq_line_fsm and the top level only.
package irq_line_pkg;

    // Line controller states; the line is low in RST, INIT and ASSERT.
    typedef enum logic [2:0] {
        ST_RST    = 3'd0,
        ST_INIT   = 3'd1,
        ST_IDLE   = 3'd2,
        ST_WAIT   = 3'd3,
        ST_ASSERT = 3'd4,
        ST_HELD   = 3'd5
    } irq_state_e;

endpackage

// File: rtl/irq_cycle_timer.sv
// Module: counts the cycles for which run stays high and flags the last one.
// Assumes: LIMIT >= 1; done is high during cycle LIMIT of an unbroken run;
//          a low run or a restart pulse returns the count to zero.
module irq_cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic done
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    // Advance while running, saturate on the final cycle, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || restart) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/irq_evt_latch.sv
// Module: one sticky status bit per event source.
// Assumes: clr wipes all bits but an event sampled in the same cycle wins;
//          cap_en low drops incoming events (reset phase).
module irq_evt_latch #(
    parameter int N_EVT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt,
    input  logic             cap_en,
    input  logic             clr,
    output logic [N_EVT-1:0] status
);
    generate
        for (genvar i = 0; i < N_EVT; i++) begin : g_bit
            // Capture, hold or clear one status bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    status[i] <= 1'b0;
                end else if (clr) begin
                    status[i] <= evt[i] & cap_en;
                end else if (evt[i] && cap_en) begin
                    status[i] <= 1'b1;
                end
            end

            // R5: an accepted event shows up in its status bit.
            p_evt_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (evt[i] && cap_en) |=> status[i]);

            // R5: a set bit survives until something clears it.
            p_bit_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (status[i] && !clr) |=> status[i]);
        end
    endgenerate

    // R9: a read with no concurrent event leaves nothing pending.
    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(|evt)) |=> (status == '0));

endmodule

// File: rtl/irq_line_fsm.sv
// Module: mask register and line state machine driving the active-low line.
// Assumes: pending is the registered OR of the status bits; the timers
//          report done on the final cycle of their windows; vddio_fall is
//          a one-cycle pulse on a supply drop.
module irq_line_fsm
    import irq_line_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vddio_ok,
    input  logic vddio_fall,
    input  logic mask_wr,
    input  logic mask_wdata,
    input  logic stat_rd,
    input  logic pending,
    input  logic rst_done,
    input  logic wait_done,
    output logic run_rst,
    output logic run_wait,
    output logic in_rst,
    output logic irq_n
);
    irq_state_e state_q, state_d;
    logic       mask_q;

    assign run_rst  = (state_q == ST_RST);
    assign run_wait = (state_q == ST_WAIT);
    assign in_rst   = run_rst || vddio_fall;
    assign irq_n    = (state_q == ST_IDLE) || (state_q == ST_WAIT) ||
                      (state_q == ST_HELD);

    // Host mask bit: forced set by any reset, writable only with supply up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
        end else if (in_rst) begin
            mask_q <= 1'b1;
        end else if (mask_wr && vddio_ok) begin
            mask_q <= mask_wdata;
        end
    end

    // Next-state selection; a supply drop overrides everything.
    always_comb begin
        state_d = state_q;
        if (vddio_fall) begin
            state_d = ST_RST;
        end else begin
            unique case (state_q)
                ST_RST:    if (rst_done) state_d = ST_INIT;
                ST_INIT:   if (!mask_q && vddio_ok)
                               state_d = pending ? ST_WAIT : ST_IDLE;
                ST_IDLE:   if (mask_q) state_d = ST_HELD;
                           else if (pending) state_d = ST_WAIT;
                ST_WAIT:   if (mask_q) state_d = ST_HELD;
                           else if (stat_rd || !pending) state_d = ST_IDLE;
                           else if (wait_done) state_d = ST_ASSERT;
                ST_ASSERT: if (mask_q) state_d = ST_HELD;
                           else if (stat_rd) state_d = ST_IDLE;
                ST_HELD:   if (!mask_q)
                               state_d = pending ? ST_WAIT : ST_IDLE;
                default:   state_d = ST_RST;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RST;
        end else begin
            state_q <= state_d;
        end
    end

    // R12: the line only falls with something to report.
    p_fall_has_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq_n) && !$past(vddio_fall)) |-> pending);

    // R8: no falling edge while the host holds the mask.
    p_masked_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && irq_n && !vddio_fall) |=> irq_n);

    // R11: a supply drop pulls the line low and re-arms the mask.
    p_vddio_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vddio_fall |=> (!irq_n && mask_q));

    // R9: reading while asserted releases the line at once.
    p_read_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ASSERT) && stat_rd && !mask_q && !vddio_fall) |=> irq_n);

    // R3: with the supply absent the mask cannot be cleared.
    p_mask_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!vddio_ok && mask_q) |=> mask_q);

endmodule

// File: rtl/irq_line_ctrl.sv
// Module: top of the maskable interrupt line controller.
// Assumes: all inputs synchronous to clk; event and strobe inputs are
//          single-cycle pulses; SW_WAIT_CYC and RST_CYC are >= 1.
module irq_line_ctrl #(
    parameter int N_EVT       = 4,
    parameter int SW_WAIT_CYC = 64,
    parameter int RST_CYC     = 12500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_pulse,
    input  logic             mask_wr,
    input  logic             mask_wdata,
    input  logic             stat_rd,
    input  logic             vddio_ok,
    output logic             irq_n,
    output logic [N_EVT-1:0] evt_status
);
    logic vddio_q;
    logic vddio_fall;
    logic run_rst, run_wait, in_rst;
    logic rst_done, wait_done;
    logic pending;

    // Remember the previous supply level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vddio_q <= 1'b0;
        end else begin
            vddio_q <= vddio_ok;
        end
    end

    assign vddio_fall = vddio_q && !vddio_ok;
    assign pending    = |evt_status;

    irq_evt_latch #(.N_EVT(N_EVT)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_pulse),
        .cap_en (!in_rst),
        .clr    (stat_rd || in_rst),
        .status (evt_status)
    );

    irq_cycle_timer #(.LIMIT(RST_CYC)) u_rst_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_rst),
        .restart (vddio_fall),
        .done    (rst_done)
    );

    irq_cycle_timer #(.LIMIT(SW_WAIT_CYC)) u_wait_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_wait),
        .restart (1'b0),
        .done    (wait_done)
    );

    irq_line_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .vddio_ok   (vddio_ok),
        .vddio_fall (vddio_fall),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .stat_rd    (stat_rd),
        .pending    (pending),
        .rst_done   (rst_done),
        .wait_done  (wait_done),
        .run_rst    (run_rst),
        .run_wait   (run_wait),
        .in_rst     (in_rst),
        .irq_n      (irq_n)
    );

endmodule

// File: tb/tb_irq_line_ctrl.sv
module tb_irq_line_ctrl;
    localparam int NE  = 4;
    localparam int SW  = 6;
    localparam int RSC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt_pulse = '0;
    logic          mask_wr = 1'b0;
    logic          mask_wdata = 1'b0;
    logic          stat_rd = 1'b0;
    logic          vddio_ok = 1'b1;
    logic          irq_n;
    logic [NE-1:0] evt_status;

    int checks = 0;
    int errors = 0;
    int fall_cnt = 0;
    bit finished = 0;
    logic irq_prev = 1'b0;

    always #4 clk = ~clk;

    irq_line_ctrl #(.N_EVT(NE), .SW_WAIT_CYC(SW), .RST_CYC(RSC)) dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .stat_rd(stat_rd), .vddio_ok(vddio_ok),
        .irq_n(irq_n), .evt_status(evt_status)
    );

    // Count falling edges of the line, sampled just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (irq_prev && !irq_n) fall_cnt++;
        irq_prev = irq_n;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_evt(input logic [NE-1:0] bits);
        evt_pulse = bits;
        step();
        evt_pulse = '0;
    endtask

    task automatic wr_mask(input logic v);
        mask_wr = 1'b1;
        mask_wdata = v;
        step();
        mask_wr = 1'b0;
    endtask

    task automatic do_read();
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
    endtask

    // Line must stay high for k-1 edges and be low after edge k.
    task automatic expect_fall_after(input string req, input int k);
        for (int i = 1; i <= k; i++) begin
            step();
            if (i < k) check(req, irq_n, 1'b1);
            else       check(req, irq_n, 1'b0);
        end
    endtask

    function automatic logic [NE-1:0] next_status(input logic [NE-1:0] cur,
                                                  input logic [NE-1:0] ev,
                                                  input logic rd);
        return rd ? ev : (cur | ev);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int f0;
        logic [NE-1:0] exp_st;
        int falls_win;
        logic prev_line;
        void'($urandom(32'd20240611));

        // R1: reset state and reset phase
        repeat (3) step();
        check("R1 line in reset", irq_n, 1'b0);
        check("R1 status in reset", evt_status, 0);
        rst_n = 1'b1;
        repeat (3) step();
        pulse_evt(4'hF);
        check("R1 event dropped in reset phase", evt_status, 0);
        wr_mask(1'b0);
        repeat (RSC) step();
        check("R3 mask write in reset phase ignored", irq_n, 1'b0);
        repeat (SW + 4) step();
        check("R2 line low while masked", irq_n, 1'b0);

        // R5/R7: deferred event
        pulse_evt(4'b0010);
        check("R5 status latched", evt_status, 4'b0010);
        repeat (SW + 3) step();
        check("R7 no edge while masked", irq_n, 1'b0);
        check("R5 status held", evt_status, 4'b0010);
        wr_mask(1'b0);
        check("R7 still low at write edge", irq_n, 1'b0);
        expect_fall_after("R7 deferred fall", SW + 1);

        // R9: read releases
        do_read();
        check("R9 status cleared", evt_status, 0);
        check("R9 line released", irq_n, 1'b1);
        repeat (SW + 4) step();
        check("R9 line stays high", irq_n, 1'b1);

        // R6: unmasked event latency, then R10 after assertion
        f0 = fall_cnt;
        pulse_evt(4'b0001);
        check("R6 high at capture", irq_n, 1'b1);
        expect_fall_after("R6 wait then fall", SW + 1);
        pulse_evt(4'b1000);
        repeat (3) step();
        check("R10 status accumulates", evt_status, 4'b1001);
        check("R10 single edge", fall_cnt - f0, 1);
        check("R10 line still low", irq_n, 1'b0);

        // R9: read with concurrent event
        stat_rd = 1'b1;
        evt_pulse = 4'b0100;
        step();
        stat_rd = 1'b0;
        evt_pulse = '0;
        check("R9 concurrent event survives", evt_status, 4'b0100);
        check("R9 release at read edge", irq_n, 1'b1);
        expect_fall_after("R9 fresh wait", SW + 1);
        do_read();

        // R10: events during the wait
        f0 = fall_cnt;
        pulse_evt(4'b0010);
        pulse_evt(4'b0001);
        pulse_evt(4'b0010);
        expect_fall_after("R10 fall with events in wait", SW - 1);
        check("R10 status", evt_status, 4'b0011);
        repeat (4) step();
        check("R10 one edge", fall_cnt - f0, 1);
        do_read();

        // R8: mask set while asserted
        pulse_evt(4'b0001);
        expect_fall_after("R6 second", SW + 1);
        wr_mask(1'b1);
        check("R8 low at write edge", irq_n, 1'b0);
        step();
        check("R8 released by mask", irq_n, 1'b1);
        pulse_evt(4'b0010);
        repeat (2 * SW) step();
        check("R8 stays high while masked", irq_n, 1'b1);
        check("R8 status kept", evt_status, 4'b0011);
        wr_mask(1'b0);
        check("R8 high at unmask", irq_n, 1'b1);
        expect_fall_after("R8 fall after unmask", SW + 1);
        do_read();

        // R11: supply drop mid-wait
        pulse_evt(4'b0010);
        step();
        step();
        vddio_ok = 1'b0;
        step();
        check("R11 line low on drop", irq_n, 1'b0);
        check("R11 status cleared on drop", evt_status, 0);
        pulse_evt(4'b0001);
        check("R11 event dropped in phase", evt_status, 0);
        repeat (RSC + 2) step();
        pulse_evt(4'b1000);
        check("R11 event latched with supply low", evt_status, 4'b1000);
        wr_mask(1'b0);
        repeat (3) step();
        vddio_ok = 1'b1;
        repeat (SW + 5) step();
        check("R3 write ignored with supply low", irq_n, 1'b0);
        wr_mask(1'b0);
        expect_fall_after("R11 reported after return", SW + 1);
        check("R11 status", evt_status, 4'b1000);
        do_read();

        // R4: unmask with nothing pending
        vddio_ok = 1'b0;
        step();
        vddio_ok = 1'b1;
        repeat (RSC + 3) step();
        check("R4 low before unmask", irq_n, 1'b0);
        wr_mask(1'b0);
        check("R4 low at write edge", irq_n, 1'b0);
        step();
        check("R4 high after second edge", irq_n, 1'b1);
        repeat (SW + 3) step();
        check("R4 stays high", irq_n, 1'b1);

        // Random traffic: R5 status model, R10 one edge per read window, R12
        exp_st = '0;
        falls_win = 0;
        prev_line = irq_n;
        for (int i = 0; i < 400; i++) begin
            logic [NE-1:0] ev;
            logic rd;
            ev = (($urandom % 4) == 0) ? NE'($urandom % 16) : '0;
            rd = (($urandom % 10) == 0);
            evt_pulse = ev;
            stat_rd = rd;
            step();
            evt_pulse = '0;
            stat_rd = 1'b0;
            exp_st = next_status(exp_st, ev, rd);
            check("R5 random status", evt_status, exp_st);
            if (prev_line && !irq_n) begin
                check("R12 fall with pending", exp_st != 0, 1'b1);
                check("R10 one edge per read", falls_win, 0);
                falls_win++;
            end
            if (rd) falls_win = 0;
            prev_line = irq_n;
        end
        repeat (SW + 3) step();
        check("R6 settled line", irq_n, exp_st == 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule